// File: doc/BRIEF.md
# Video operand handoff stall controller

This block couples a CPU core to a video shifter when the two run from clocks with no fixed phase relation. The CPU presents a colour word and a pixel word together with a wait request. The block buffers both words and stalls the CPU. The video side counts down its own frame on the video clock. Each time a frame expires, it samples the buffered operands and the frame-scale setting for the next frame, and it raises a one-cycle fetch pulse. It does this whether or not a request is pending.

The fetch pulse is turned into a toggle and carried back to the CPU clock through a flop synchronizer. An edge on the synchronized toggle ends the stall. Only edges caused by a fetch that took place after the request was accepted count. A request that arrives just after a frame boundary therefore waits for the next boundary. The stall never lasts fewer than a fixed number of CPU cycles.

Top module: `vid_handoff`

## Requirements
- R1: While the resets are held and just after they are released, `busy` is 0, the captured colour and pixel words are 0 and `vid_scale` holds the default scale. The first `vid_fetch` pulse comes exactly DEF_FLEN video cycles after the video reset is released.
- R2: The scale word is laid out as {clocks_per_pixel[CPP_W-1:0], frame_length[FLEN_W-1:0]}. The number of video cycles from one `vid_fetch` pulse to the next equals the frame length captured at the first of the two pulses. A scale written through `scale_we` takes effect only at the next frame boundary.
- R3: A frame length of 0 or 1 is treated as a frame of 2 video cycles.
- R4: At every frame boundary, `vid_colour`, `vid_pixel` and `vid_scale` take the values of the CPU-side operand and scale registers, with or without a pending request. `vid_fetch` is high for exactly that one video cycle. The captured values do not change between boundaries.
- R5: A request made while `busy` is 0 is accepted at that clock edge. `busy` is 1 in the next cycle, and the request's colour and pixel words are buffered.
- R6: While `busy` is 1, further requests are ignored and the buffered operands stay unchanged.
- R7: Each stall keeps `busy` high for at least MIN_CYC (default 6) CPU cycles.
- R8: A stall ends only after a fetch whose video edge follows the accepting CPU edge. When `busy` falls, the captured colour and pixel words equal the request's operands, including for a request made right after a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU clock |
| cpu_rst | input | 1 | Synchronous active-high reset, CPU domain |
| req | input | 1 | Wait-for-video request |
| req_colour | input | COL_W | Colour operand of the request |
| req_pixel | input | PIX_W | Pixel operand of the request |
| scale_we | input | 1 | Write strobe for the scale register |
| scale_wdata | input | CPP_W+FLEN_W | New scale value {clocks per pixel, frame length} |
| busy | output | 1 | CPU stall, high from acceptance until release |
| vid_clk | input | 1 | Video clock |
| vid_rst | input | 1 | Synchronous active-high reset, video domain |
| vid_fetch | output | 1 | One-cycle pulse at each frame boundary |
| vid_colour | output | COL_W | Colour word captured for the current frame |
| vid_pixel | output | PIX_W | Pixel word captured for the current frame |
| vid_scale | output | CPP_W+FLEN_W | Scale captured for the current frame |

## Verification
The bench builds the block with 16-bit operands, a 6-bit frame-length field and a default frame of 10 video cycles. This keeps frames short enough that dozens of stalls, many frame boundaries and several scale changes fit in one run. The video period is 7.034 ns against the 4 ns CPU period, and the video edges fall on odd picoseconds. The phase of each request against the frame boundary therefore drifts over the whole cycle, and no edge ever ties with a CPU edge. Scale writes of 0 and 1 reach the two-cycle floor. Requests issued directly after an observed fetch reach the case where the stall must skip a whole frame.

// File: rtl/vh_pkg.sv
package vh_pkg;

  // shortest frame the video counter can run, in video clocks
  localparam int unsigned MIN_FRAME = 2;

  // default lower bound of a stall, in CPU clocks
  localparam int unsigned STALL_MIN = 6;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vh_cpu_stall.sv
module vh_cpu_stall #(
  parameter int unsigned COL_W   = 32,
  parameter int unsigned PIX_W   = 32,
  parameter int unsigned SC_W    = 12,
  parameter int unsigned GUARD   = 3,
  parameter int unsigned MIN_CYC = 6,
  parameter logic [SC_W-1:0] DEF_SCALE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [COL_W-1:0] req_colour,
  input  logic [PIX_W-1:0] req_pixel,
  input  logic             scale_we,
  input  logic [SC_W-1:0]  scale_wdata,
  input  logic             rel_pulse,
  output logic             busy,
  output logic [COL_W-1:0] op_colour,
  output logic [PIX_W-1:0] op_pixel,
  output logic [SC_W-1:0]  scale_q
);

  localparam int unsigned SAT  = vh_pkg::max_u(GUARD, MIN_CYC);
  localparam int unsigned EL_W = $clog2(SAT + 1);
  localparam logic [EL_W-1:0] SAT_V   = EL_W'(SAT);
  localparam logic [EL_W-1:0] GUARD_V = EL_W'(GUARD);
  localparam logic [EL_W-1:0] MIN_V   = EL_W'(MIN_CYC);

  logic [EL_W-1:0] elapsed;   // CPU edges since acceptance, saturating
  logic            rel_seen;  // a valid release already arrived
  logic            accept;
  logic            rel_ok;
  logic            done;

  // release edges seen before GUARD cycles may come from a fetch that
  // preceded acceptance, so they are discarded
  always_comb begin
    accept = req && !busy;
    rel_ok = rel_pulse && (elapsed >= GUARD_V);
    done   = (rel_seen || rel_ok) && (elapsed >= MIN_V);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      elapsed   <= '0;
      rel_seen  <= 1'b0;
      op_colour <= '0;
      op_pixel  <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      elapsed   <= EL_W'(1);
      rel_seen  <= 1'b0;
      op_colour <= req_colour;
      op_pixel  <= req_pixel;
    end else if (busy) begin
      if (done) begin
        busy     <= 1'b0;
        rel_seen <= 1'b0;
      end else begin
        rel_seen <= rel_seen || rel_ok;
      end
      if (elapsed != SAT_V) begin
        elapsed <= elapsed + EL_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scale_q <= DEF_SCALE;
    end else if (scale_we) begin
      scale_q <= scale_wdata;
    end
  end

endmodule

// File: rtl/vh_toggle_sync.sv
module vh_toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tog_in,
  output logic pulse
);

  logic [STAGES-1:0] chain;
  logic              last;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= tog_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], tog_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= 1'b0;
    else     last <= chain[STAGES-1];
  end

  assign pulse = chain[STAGES-1] ^ last;

endmodule

// File: rtl/vh_frame_fetch.sv
module vh_frame_fetch #(
  parameter int unsigned COL_W  = 32,
  parameter int unsigned PIX_W  = 32,
  parameter int unsigned FLEN_W = 8,
  parameter int unsigned SC_W   = 12,
  parameter logic [SC_W-1:0] DEF_SCALE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [COL_W-1:0] op_colour,
  input  logic [PIX_W-1:0] op_pixel,
  input  logic [SC_W-1:0]  scale_q,
  output logic             fetch,
  output logic             fetch_tog,
  output logic [COL_W-1:0] colour,
  output logic [PIX_W-1:0] pixel,
  output logic [SC_W-1:0]  scale
);

  localparam logic [FLEN_W-1:0] FLOOR = FLEN_W'(vh_pkg::MIN_FRAME);
  localparam logic [FLEN_W-1:0] ONE   = FLEN_W'(1);

  function automatic logic [FLEN_W-1:0] eff_len(input logic [FLEN_W-1:0] l);
    return (l < FLOOR) ? FLOOR : l;
  endfunction

  logic [FLEN_W-1:0] remain;
  logic              expire;

  assign expire = (remain == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain    <= eff_len(DEF_SCALE[FLEN_W-1:0]);
      fetch     <= 1'b0;
      fetch_tog <= 1'b0;
      colour    <= '0;
      pixel     <= '0;
      scale     <= DEF_SCALE;
    end else if (expire) begin
      remain    <= eff_len(scale_q[FLEN_W-1:0]);
      fetch     <= 1'b1;
      fetch_tog <= ~fetch_tog;
      colour    <= op_colour;
      pixel     <= op_pixel;
      scale     <= scale_q;
    end else begin
      remain    <= remain - ONE;
      fetch     <= 1'b0;
    end
  end

endmodule

// File: rtl/vid_handoff.sv
module vid_handoff #(
  parameter int unsigned COL_W       = 32,
  parameter int unsigned PIX_W       = 32,
  parameter int unsigned FLEN_W      = 8,
  parameter int unsigned CPP_W       = 4,
  parameter int unsigned DEF_FLEN    = 16,
  parameter int unsigned DEF_CPP     = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_CYC     = vh_pkg::STALL_MIN
) (
  input  logic                    cpu_clk,
  input  logic                    cpu_rst,
  input  logic                    req,
  input  logic [COL_W-1:0]        req_colour,
  input  logic [PIX_W-1:0]        req_pixel,
  input  logic                    scale_we,
  input  logic [CPP_W+FLEN_W-1:0] scale_wdata,
  output logic                    busy,
  input  logic                    vid_clk,
  input  logic                    vid_rst,
  output logic                    vid_fetch,
  output logic [COL_W-1:0]        vid_colour,
  output logic [PIX_W-1:0]        vid_pixel,
  output logic [CPP_W+FLEN_W-1:0] vid_scale
);

  localparam int unsigned SC_W  = CPP_W + FLEN_W;
  localparam int unsigned GUARD = SYNC_STAGES + 1;
  localparam logic [SC_W-1:0] DEF_SCALE = {CPP_W'(DEF_CPP), FLEN_W'(DEF_FLEN)};

  logic [COL_W-1:0] op_colour;
  logic [PIX_W-1:0] op_pixel;
  logic [SC_W-1:0]  scale_q;
  logic             fetch_tog;
  logic             rel_pulse;

  vh_cpu_stall #(
    .COL_W(COL_W), .PIX_W(PIX_W), .SC_W(SC_W),
    .GUARD(GUARD), .MIN_CYC(MIN_CYC), .DEF_SCALE(DEF_SCALE)
  ) u_cpu (
    .clk(cpu_clk), .rst(cpu_rst),
    .req(req), .req_colour(req_colour), .req_pixel(req_pixel),
    .scale_we(scale_we), .scale_wdata(scale_wdata),
    .rel_pulse(rel_pulse), .busy(busy),
    .op_colour(op_colour), .op_pixel(op_pixel), .scale_q(scale_q)
  );

  vh_frame_fetch #(
    .COL_W(COL_W), .PIX_W(PIX_W), .FLEN_W(FLEN_W), .SC_W(SC_W),
    .DEF_SCALE(DEF_SCALE)
  ) u_vid (
    .clk(vid_clk), .rst(vid_rst),
    .op_colour(op_colour), .op_pixel(op_pixel), .scale_q(scale_q),
    .fetch(vid_fetch), .fetch_tog(fetch_tog),
    .colour(vid_colour), .pixel(vid_pixel), .scale(vid_scale)
  );

  vh_toggle_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(cpu_clk), .rst(cpu_rst), .tog_in(fetch_tog), .pulse(rel_pulse)
  );

endmodule

// File: rtl/vid_handoff_chk.sv
module vid_handoff_chk #(
  parameter int unsigned COL_W   = 32,
  parameter int unsigned PIX_W   = 32,
  parameter int unsigned SC_W    = 12,
  parameter int unsigned MIN_CYC = 6
) (
  input logic             cpu_clk,
  input logic             cpu_rst,
  input logic             vid_clk,
  input logic             vid_rst,
  input logic             req,
  input logic             busy,
  input logic [COL_W-1:0] op_colour,
  input logic [PIX_W-1:0] op_pixel,
  input logic             vid_fetch,
  input logic [COL_W-1:0] vid_colour,
  input logic [PIX_W-1:0] vid_pixel,
  input logic [SC_W-1:0]  vid_scale
);

  localparam int unsigned HW = $clog2(MIN_CYC + 2);
  localparam logic [HW-1:0] HMAX = HW'(MIN_CYC + 1);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge cpu_clk) begin
    if (cpu_rst || !busy) hi_cnt <= '0;
    else if (hi_cnt != HMAX) hi_cnt <= hi_cnt + HW'(1);
  end

  a_r5_busy_from_req: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    $rose(busy) |-> $past(req));

  a_r6_ops_held: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    (busy && $past(busy)) |-> ($stable(op_colour) && $stable(op_pixel)));

  a_r7_min_stall: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    $fell(busy) |-> (hi_cnt >= HW'(MIN_CYC)));

  a_r4_fetch_single: assert property (@(posedge vid_clk) disable iff (vid_rst)
    vid_fetch |=> !vid_fetch);

  a_r4_capture_hold: assert property (@(posedge vid_clk) disable iff (vid_rst)
    !vid_fetch |-> ($stable(vid_colour) && $stable(vid_pixel) && $stable(vid_scale)));

endmodule

bind vid_handoff vid_handoff_chk #(
  .COL_W(COL_W), .PIX_W(PIX_W), .SC_W(SC_W), .MIN_CYC(MIN_CYC)
) u_chk (
  .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .vid_clk(vid_clk), .vid_rst(vid_rst),
  .req(req), .busy(busy), .op_colour(op_colour), .op_pixel(op_pixel),
  .vid_fetch(vid_fetch), .vid_colour(vid_colour), .vid_pixel(vid_pixel),
  .vid_scale(vid_scale)
);

// File: tb/vid_handoff_tb.sv
`timescale 1ns/1ps
module vid_handoff_tb;

  localparam int COL_W = 16, PIX_W = 16, FLEN_W = 6, CPP_W = 4;
  localparam int DEF_FLEN = 10, DEF_CPP = 1, MIN_CYC = 6;
  localparam int SC_W = CPP_W + FLEN_W;
  localparam logic [SC_W-1:0] DEF_SCALE = {CPP_W'(DEF_CPP), FLEN_W'(DEF_FLEN)};
  localparam realtime VHALF = 3.517;

  logic cpu_clk = 0, vid_clk = 0;
  logic cpu_rst = 1, vid_rst = 1;
  logic req = 0, scale_we = 0;
  logic [COL_W-1:0] req_colour = '0;
  logic [PIX_W-1:0] req_pixel = '0;
  logic [SC_W-1:0]  scale_wdata = '0;
  logic busy, vid_fetch;
  logic [COL_W-1:0] vid_colour;
  logic [PIX_W-1:0] vid_pixel;
  logic [SC_W-1:0]  vid_scale;

  vid_handoff #(
    .COL_W(COL_W), .PIX_W(PIX_W), .FLEN_W(FLEN_W), .CPP_W(CPP_W),
    .DEF_FLEN(DEF_FLEN), .DEF_CPP(DEF_CPP), .SYNC_STAGES(2), .MIN_CYC(MIN_CYC)
  ) u_dut (.*);

  always #2.0 cpu_clk = ~cpu_clk;
  initial begin
    #1.0;
    forever #(VHALF) vid_clk = ~vid_clk;
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int eff_len(input logic [SC_W-1:0] s);
    int l = int'(s[FLEN_W-1:0]);
    return (l < 2) ? 2 : l;
  endfunction

  // bench model of CPU-side registers
  logic [COL_W-1:0] m_col = '0;
  logic [PIX_W-1:0] m_pix = '0;
  logic [SC_W-1:0]  m_scale = DEF_SCALE;
  realtime t_acc = 0.0, t_scw = 0.0, last_fetch_t = 0.0;

  // video-side monitor: frame spacing and captured values
  int v_gap = 0, exp_gap = DEF_FLEN, n_fetch = 0;
  string gap_tag = "R1";
  always @(negedge vid_clk) begin
    if (vid_rst) begin
      v_gap = 0;
    end else begin
      v_gap++;
      if (vid_fetch) begin
        n_fetch++;
        last_fetch_t = $realtime - VHALF;
        chk(v_gap == exp_gap, gap_tag, "video cycles between fetches", v_gap, exp_gap);
        if ($realtime - t_scw > 20.0)
          chk(vid_scale == m_scale, "R2", "captured scale", vid_scale, m_scale);
        if ($realtime - t_acc > 20.0) begin
          chk(vid_colour == m_col, "R4", "captured colour", vid_colour, m_col);
          chk(vid_pixel == m_pix, "R4", "captured pixel", vid_pixel, m_pix);
        end
        exp_gap = eff_len(vid_scale);
        gap_tag = (vid_scale[FLEN_W-1:0] < 2) ? "R3" : "R2";
        v_gap = 0;
      end
    end
  end

  task automatic wr_scale(input int len, input int cpp);
    while (busy) @(negedge cpu_clk);
    @(negedge cpu_clk);
    scale_we = 1;
    scale_wdata = {CPP_W'(cpp), FLEN_W'(len)};
    @(negedge cpu_clk);
    scale_we = 0;
    m_scale = scale_wdata;
    t_scw = $realtime;
  endtask

  task automatic do_req(input logic [COL_W-1:0] c, input logic [PIX_W-1:0] p,
                        input bit poke, input bit sync_to_fetch);
    realtime tacc;
    int hi;
    while (busy) @(negedge cpu_clk);
    if (c == m_col) c = c ^ 1;
    if (p == m_pix) p = p ^ 1;
    if (sync_to_fetch) begin
      @(posedge vid_fetch);
    end
    @(negedge cpu_clk);
    req = 1; req_colour = c; req_pixel = p;
    tacc = $realtime + 2.0;
    @(negedge cpu_clk);
    req = 0;
    m_col = c; m_pix = p; t_acc = tacc;
    chk(busy == 1'b1, "R5", "busy after accepted request", busy, 1);
    hi = 0;
    while (busy) begin
      hi++;
      if (poke && hi == 2) begin
        req = 1; req_colour = ~c; req_pixel = ~p;
      end else begin
        req = 0;
      end
      @(negedge cpu_clk);
    end
    req = 0;
    chk(hi >= MIN_CYC, "R7", "stall length in CPU cycles", hi, MIN_CYC);
    chk(last_fetch_t > tacc, "R8", "releasing fetch after acceptance", longint'(last_fetch_t), longint'(tacc));
    chk(vid_colour == c, "R8", "colour captured at release", vid_colour, c);
    chk(vid_pixel == p, "R8", "pixel captured at release", vid_pixel, p);
    if (poke) begin
      repeat (3) @(negedge cpu_clk);
      chk(busy == 1'b0, "R6", "no stall from ignored request", busy, 0);
      chk(vid_colour == c, "R6", "ignored request left operands", vid_colour, c);
    end
  endtask

  initial begin
    repeat (150000) @(posedge cpu_clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    @(negedge vid_clk);
    repeat (3) @(negedge vid_clk);
    #1.0;
    vid_rst = 0;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge cpu_clk);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(vid_colour == '0, "R1", "colour in reset", vid_colour, 0);
    chk(vid_fetch == 1'b0, "R1", "fetch in reset", vid_fetch, 0);
    chk(vid_scale == DEF_SCALE, "R1", "scale in reset", vid_scale, DEF_SCALE);
    cpu_rst = 0;
    repeat (2) @(negedge cpu_clk);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);

    // directed: basic requests, one right after a fetch, one ignored re-request
    do_req(16'h1234, 16'hA5A5, 0, 0);
    do_req(16'h0F0F, 16'h5555, 0, 1);
    do_req(16'hBEEF, 16'h0101, 1, 0);
    // directed: short frames at the floor
    wr_scale(0, 2);
    repeat (40) @(negedge cpu_clk);
    do_req(16'h7777, 16'h8888, 0, 0);
    wr_scale(1, 3);
    repeat (40) @(negedge cpu_clk);
    wr_scale(12, 1);
    repeat (60) @(negedge cpu_clk);
    do_req(16'hCAFE, 16'h3C3C, 0, 1);

    // random mix
    for (int i = 0; i < 60; i++) begin
      int sel = int'($urandom % 8);
      if (sel == 0) begin
        int len = ($urandom % 6 == 0) ? int'($urandom % 2) : 2 + int'($urandom % 20);
        wr_scale(len, int'($urandom % 16));
      end else begin
        do_req(COL_W'($urandom), PIX_W'($urandom), ($urandom % 4) == 0, ($urandom % 3) == 0);
      end
      repeat ($urandom % 30) @(negedge cpu_clk);
    end
    repeat (200) @(negedge cpu_clk);
    chk(n_fetch > 20, "R2", "frames observed", n_fetch, 21);
    finish_up();
  end

endmodule